// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache

This block sits between a processor-side request stream and a line-wide main-memory port. Each request carries a byte address, a read/write flag and a data word. The address is cut into three fields: the low bits select a byte within a line, the middle bits pick one of the cache lines, and the high bits form the tag kept beside that line. A request hits when the selected line is valid and its stored tag equals the request tag. A read hit returns the addressed word. A write hit merges the word into the line and marks the line modified. No memory traffic occurs on a hit.

On a miss the controller evicts whatever line occupies the selected slot. If that line is modified, it is first written back whole to its own aligned address. The aligned line that holds the requested word is then read in whole, and the request is retried against the refreshed line. The retry always hits. The response flags the request as a miss. Because each line index has only one slot, two addresses that share an index but differ in tag keep displacing each other.

Requests and responses each use a valid/ready handshake. A request is taken on a cycle where `req_valid` and `req_ready` are both high. After that, `req_ready` stays low until the response has been taken. A response is offered with `rsp_valid` and held unchanged until `rsp_ready` is high on a clock edge. The memory request side uses the same rule: `mem_req_valid`, `mem_we`, `mem_addr` and `mem_wdata` stay stable until `mem_req_ready` is sampled high. Fill data returns as a single-cycle `mem_rsp_valid` pulse, and the block is always ready to take it.

Top module: `dm_cache`

## Requirements
- R1: After reset every line is invalid and clean. `req_ready` is 1, while `rsp_valid` and `mem_req_valid` are 0. The first access to any line therefore misses.
- R2: For a byte address, bits [log2(LINE_BYTES)-1:0] are the offset within the line, and the word within the line is offset bits [log2(LINE_BYTES)-1:2] for 32-bit words. The next log2(LINES) bits are the line index, and all remaining upper bits are the tag. With 16-byte lines and 8 lines, byte address 0x8000_0024 has index 2 and a tag whose top bit is set.
- R3: A request to a valid line whose tag matches responds with `rsp_hit`=1 and issues no memory request. A read returns the addressed word.
- R4: A miss issues exactly one memory read. Its `mem_addr` is the full requesting byte address. The returned line is stored whole, so later accesses to any word of that aligned line hit.
- R5: An access with the same index but a different tag misses and replaces the resident line. With 4-word, 8-line geometry, the word-address trace 1, 7, 6, 5, 32, 33, 1, 2 yields miss, miss, hit, hit, miss, hit, miss, hit.
- R6: A write hit updates only the addressed word and marks the line modified. It causes no memory write, and a later read of that word returns the written value.
- R7: A miss on a modified line first issues one memory write. That write carries the old line's content, and its `mem_addr` is the old line's aligned address {old tag, index, zero offset}. The fill follows the write.
- R8: A miss on an unmodified line issues no memory write.
- R9: `req_ready` is 0 from the cycle after a request is taken, through any miss handling, until the response is taken.
- R10: While `rsp_valid`=1 and `rsp_ready`=0, `rsp_valid`, `rsp_data` and `rsp_hit` hold their values.
- R11: A write miss fills the line, then merges the word and marks the line modified. Its response carries `rsp_hit`=0 and `rsp_data` equal to the written word. The other words of the line keep the memory values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can take a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | WORD_W | Write data word |
| rsp_valid | output | 1 | Response offered |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | WORD_W | Read word, or the written word for writes |
| rsp_hit | output | 1 | 1 if the request hit on first lookup |
| mem_req_valid | output | 1 | Memory request offered |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_we | output | 1 | 1 = line write-back, 0 = line fill |
| mem_addr | output | ADDR_W | Aligned line address (write) or requesting address (fill) |
| mem_wdata | output | LINE_BYTES*8 | Line being written back |
| mem_rsp_valid | input | 1 | Fill line returned |
| mem_rsp_data | input | LINE_BYTES*8 | Fill line content |

## Verification
The bench builds the block with 8 lines of four 32-bit words. The 32-bit address and the 16-byte line of the default build are kept, and only the line count shrinks. This small geometry lets short word-address traces alias onto the same index. The bench can then drive the displacement pattern of R5 exactly, force evictions of both modified and unmodified lines, and check each write-back address and content against a memory model a few dozen lines deep. A tag that differs only in its top address bit also exercises the full width of the tag comparison.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_EVICT,
    ST_FILL,
    ST_WAIT,
    ST_RESP
  } dmc_state_t;

endpackage

// File: rtl/dmc_addr_split.sv
module dmc_addr_split #(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int LINES      = 4096,
  localparam int BSEL_W    = $clog2(WORD_W / 8),
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int WSEL_W    = OFF_W - BSEL_W,
  localparam int IDX_W     = $clog2(LINES),
  localparam int TAG_W     = ADDR_W - OFF_W - IDX_W
) (
  input  logic [ADDR_W-1:BSEL_W] waddr_i,
  output logic [TAG_W-1:0]       tag_o,
  output logic [IDX_W-1:0]       idx_o,
  output logic [WSEL_W-1:0]      wsel_o
);

  assign wsel_o = waddr_i[OFF_W-1:BSEL_W];
  assign idx_o  = waddr_i[OFF_W+IDX_W-1:OFF_W];
  assign tag_o  = waddr_i[ADDR_W-1:OFF_W+IDX_W];

endmodule

// File: rtl/dmc_line_store.sv
module dmc_line_store #(
  parameter int TAG_W  = 16,
  parameter int LINE_W = 128,
  parameter int LINES  = 4096,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              we_i,
  input  logic              dirty_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [LINE_W-1:0] line_i,
  output logic              valid_o,
  output logic              dirty_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [LINE_W-1:0] line_o
);

  logic [LINES-1:0]  valid_q;
  logic [LINES-1:0]  dirty_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [LINE_W-1:0] data_q [LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (we_i) begin
      valid_q[idx_i] <= 1'b1;
      dirty_q[idx_i] <= dirty_i;
    end
  end

  always_ff @(posedge clk) begin
    if (we_i) begin
      tag_q[idx_i]  <= tag_i;
      data_q[idx_i] <= line_i;
    end
  end

  assign valid_o = valid_q[idx_i];
  assign dirty_o = dirty_q[idx_i];
  assign tag_o   = tag_q[idx_i];
  assign line_o  = data_q[idx_i];

endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import dmc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int LINES      = 4096,
  localparam int BSEL_W    = $clog2(WORD_W / 8),
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int WSEL_W    = OFF_W - BSEL_W,
  localparam int WORDS     = LINE_BYTES / (WORD_W / 8),
  localparam int IDX_W     = $clog2(LINES),
  localparam int TAG_W     = ADDR_W - OFF_W - IDX_W,
  localparam int LINE_W    = LINE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [WORD_W-1:0] rsp_data,
  output logic              rsp_hit,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LINE_W-1:0] mem_wdata,
  input  logic              mem_rsp_valid,
  input  logic [LINE_W-1:0] mem_rsp_data,
  output logic [ADDR_W-1:0] cur_addr_o,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [WSEL_W-1:0] wsel_i,
  input  logic              rd_valid_i,
  input  logic              rd_dirty_i,
  input  logic [TAG_W-1:0]  rd_tag_i,
  input  logic [LINE_W-1:0] rd_line_i,
  output logic              st_we_o,
  output logic              st_dirty_o,
  output logic [TAG_W-1:0]  st_tag_o,
  output logic [LINE_W-1:0] st_line_o
);

  dmc_state_t        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] wdata_q;
  logic              we_q;
  logic              missed_q;
  logic [WORD_W-1:0] rsp_data_q;
  logic              rsp_hit_q;

  logic              hit;
  logic [WORD_W-1:0] words  [WORDS];
  logic [LINE_W-1:0] merged;

  // Split the resident line into words and build the write-merged line.
  for (genvar g = 0; g < WORDS; g++) begin : g_word
    assign words[g] = rd_line_i[g*WORD_W +: WORD_W];
    assign merged[g*WORD_W +: WORD_W] =
      (wsel_i == WSEL_W'(g)) ? wdata_q : rd_line_i[g*WORD_W +: WORD_W];
  end

  assign hit        = rd_valid_i && (rd_tag_i == tag_i);
  assign cur_addr_o = addr_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (req_valid) state_d = ST_LOOK;
      ST_LOOK: begin
        if (hit)                          state_d = ST_RESP;
        else if (rd_valid_i && rd_dirty_i) state_d = ST_EVICT;
        else                              state_d = ST_FILL;
      end
      ST_EVICT: if (mem_req_ready) state_d = ST_FILL;
      ST_FILL:  if (mem_req_ready) state_d = ST_WAIT;
      ST_WAIT:  if (mem_rsp_valid) state_d = ST_LOOK;
      ST_RESP:  if (rsp_ready)     state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      addr_q     <= '0;
      wdata_q    <= '0;
      we_q       <= 1'b0;
      missed_q   <= 1'b0;
      rsp_data_q <= '0;
      rsp_hit_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && req_valid) begin
        addr_q   <= req_addr;
        wdata_q  <= req_wdata;
        we_q     <= req_we;
        missed_q <= 1'b0;
      end
      if (state_q == ST_LOOK) begin
        if (hit) begin
          rsp_data_q <= we_q ? wdata_q : words[wsel_i];
          rsp_hit_q  <= !missed_q;
        end else begin
          missed_q <= 1'b1;
        end
      end
    end
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign rsp_valid     = (state_q == ST_RESP);
  assign rsp_data      = rsp_data_q;
  assign rsp_hit       = rsp_hit_q;

  assign mem_req_valid = (state_q == ST_EVICT) || (state_q == ST_FILL);
  assign mem_we        = (state_q == ST_EVICT);
  assign mem_addr      = (state_q == ST_EVICT) ? {rd_tag_i, idx_i, {OFF_W{1'b0}}} : addr_q;
  assign mem_wdata     = rd_line_i;

  assign st_we_o    = ((state_q == ST_LOOK) && hit && we_q) ||
                      ((state_q == ST_WAIT) && mem_rsp_valid);
  assign st_dirty_o = (state_q == ST_LOOK);
  assign st_tag_o   = tag_i;
  assign st_line_o  = (state_q == ST_WAIT) ? mem_rsp_data : merged;

endmodule

// File: rtl/dm_cache.sv
module dm_cache #(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int LINES      = 4096,
  localparam int BSEL_W    = $clog2(WORD_W / 8),
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int WSEL_W    = OFF_W - BSEL_W,
  localparam int IDX_W     = $clog2(LINES),
  localparam int TAG_W     = ADDR_W - OFF_W - IDX_W,
  localparam int LINE_W    = LINE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [WORD_W-1:0] rsp_data,
  output logic              rsp_hit,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LINE_W-1:0] mem_wdata,
  input  logic              mem_rsp_valid,
  input  logic [LINE_W-1:0] mem_rsp_data
);

  logic [ADDR_W-1:0] cur_addr;
  logic [TAG_W-1:0]  tag;
  logic [IDX_W-1:0]  idx;
  logic [WSEL_W-1:0] wsel;
  logic              rd_valid, rd_dirty;
  logic [TAG_W-1:0]  rd_tag;
  logic [LINE_W-1:0] rd_line;
  logic              st_we, st_dirty;
  logic [TAG_W-1:0]  st_tag;
  logic [LINE_W-1:0] st_line;

  dmc_addr_split #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINE_BYTES(LINE_BYTES), .LINES(LINES)
  ) u_split (
    .waddr_i (cur_addr[ADDR_W-1:BSEL_W]),
    .tag_o   (tag),
    .idx_o   (idx),
    .wsel_o  (wsel)
  );

  dmc_line_store #(
    .TAG_W(TAG_W), .LINE_W(LINE_W), .LINES(LINES)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .idx_i   (idx),
    .we_i    (st_we),
    .dirty_i (st_dirty),
    .tag_i   (st_tag),
    .line_i  (st_line),
    .valid_o (rd_valid),
    .dirty_o (rd_dirty),
    .tag_o   (rd_tag),
    .line_o  (rd_line)
  );

  dmc_ctrl #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINE_BYTES(LINE_BYTES), .LINES(LINES)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_we        (req_we),
    .req_addr      (req_addr),
    .req_wdata     (req_wdata),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_data      (rsp_data),
    .rsp_hit       (rsp_hit),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .cur_addr_o    (cur_addr),
    .tag_i         (tag),
    .idx_i         (idx),
    .wsel_i        (wsel),
    .rd_valid_i    (rd_valid),
    .rd_dirty_i    (rd_dirty),
    .rd_tag_i      (rd_tag),
    .rd_line_i     (rd_line),
    .st_we_o       (st_we),
    .st_dirty_o    (st_dirty),
    .st_tag_o      (st_tag),
    .st_line_o     (st_line)
  );

endmodule

// File: rtl/dm_cache_chk.sv
module dm_cache_chk #(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_BYTES = 16,
  localparam int OFF_W     = $clog2(LINE_BYTES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [WORD_W-1:0] rsp_data,
  input logic              rsp_hit,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr
);

  // R9: a taken request makes the block busy on the next cycle
  p_busy_after_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  // R9: no new request is taken while a response is pending
  p_busy_with_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R10: a stalled response holds
  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_hit));

  // R3: a first-lookup hit is never answered alongside memory traffic
  p_hit_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_hit |-> !mem_req_valid);

  // R7: write-backs target an aligned line address
  p_wb_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_we |-> mem_addr[OFF_W-1:0] == '0);

  // R7: a stalled memory request holds
  p_mem_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_we) && $stable(mem_addr));

endmodule

bind dm_cache dm_cache_chk #(
  .ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINE_BYTES(LINE_BYTES)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_data      (rsp_data),
  .rsp_hit       (rsp_hit),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_we        (mem_we),
  .mem_addr      (mem_addr)
);

// File: tb/dm_cache_bench.sv
`timescale 1ns/1ps
module dm_cache_bench;

  localparam int CYC    = 20;
  localparam int LINE_W = 128;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic              req_we = 1'b0;
  logic [31:0]       req_addr = '0;
  logic [31:0]       req_wdata = '0;
  logic              rsp_valid;
  logic              rsp_ready = 1'b1;
  logic [31:0]       rsp_data;
  logic              rsp_hit;
  logic              mem_req_valid;
  logic              mem_req_ready = 1'b1;
  logic              mem_we;
  logic [31:0]       mem_addr;
  logic [LINE_W-1:0] mem_wdata;
  logic              mem_rsp_valid = 1'b0;
  logic [LINE_W-1:0] mem_rsp_data = '0;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [LINE_W-1:0] mem_line [64];
  int          rd_cnt = 0;
  int          wr_cnt = 0;
  int          pend   = 0;
  logic [5:0]  fill_idx = '0;
  logic [31:0] last_fill_addr = '0;
  logic [31:0] last_wb_addr   = '0;

  always #(CYC/2) clk = ~clk;

  dm_cache #(.LINES(8)) u_dm_cache (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_hit(rsp_hit),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  // Main-memory model, acting between clock edges.
  always @(negedge clk) begin
    if (mem_rsp_valid) mem_rsp_valid = 1'b0;
    if (mem_req_valid && mem_we) begin
      mem_line[mem_addr[9:4]] = mem_wdata;
      last_wb_addr = mem_addr;
      wr_cnt++;
    end else if (mem_req_valid) begin
      fill_idx = mem_addr[9:4];
      last_fill_addr = mem_addr;
      pend = 2;
      rd_cnt++;
    end else if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem_line[fill_idx];
      end
    end
  end

  function automatic logic [31:0] init_word(input int w);
    return 32'h1000_0000 + 32'(w);
  endfunction

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic access(input logic [31:0] baddr, input logic we, input logic [31:0] wd,
                        input logic exp_hit, input logic [31:0] exp_d, input string rq);
    bit busy_ok = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, {rq, " ready before request"}, 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_we = we; req_addr = baddr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;
    while (!rsp_valid) begin
      if (req_ready) busy_ok = 1'b0;
      @(negedge clk);
    end
    if (req_ready) busy_ok = 1'b0;
    check(busy_ok, {rq, " R9 busy while serving"}, 32'(busy_ok), 32'd1);
    check(rsp_hit == exp_hit, {rq, " hit flag"}, 32'(rsp_hit), 32'(exp_hit));
    check(rsp_data == exp_d, {rq, " data"}, rsp_data, exp_d);
  endtask

  task automatic t_reset;
    check(req_ready == 1'b1, "R1 req_ready after reset", 32'(req_ready), 32'd1);
    check(rsp_valid == 1'b0, "R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    check(mem_req_valid == 1'b0, "R1 mem_req_valid after reset", 32'(mem_req_valid), 32'd0);
  endtask

  task automatic t_trace;
    int          tr [8]   = '{1, 7, 6, 5, 32, 33, 1, 2};
    logic        hitv [8] = '{0, 0, 1, 1, 0, 1, 0, 1};
    for (int i = 0; i < 8; i++)
      access(32'(tr[i]) * 4, 1'b0, '0, hitv[i], init_word(tr[i]), "R5 trace step");
    check(rd_cnt == 4, "R4 one fill per miss", 32'(rd_cnt), 32'd4);
    check(last_fill_addr == 32'd4, "R4 fill carries request address", last_fill_addr, 32'd4);
    check(wr_cnt == 0, "R8 clean evictions write nothing", 32'(wr_cnt), 32'd0);
  endtask

  task automatic t_writeback;
    access(32'd8, 1'b1, 32'hDEAD_0002, 1'b1, 32'hDEAD_0002, "R6 write hit");
    check(wr_cnt == 0, "R6 write hit causes no memory write", 32'(wr_cnt), 32'd0);
    access(32'd8, 1'b0, '0, 1'b1, 32'hDEAD_0002, "R6 read after write hit");
    access(32'd136, 1'b0, '0, 1'b0, init_word(34), "R7 miss on modified line");
    check(wr_cnt == 1, "R7 one write-back", 32'(wr_cnt), 32'd1);
    check(last_wb_addr == 32'd0, "R7 write-back address", last_wb_addr, 32'd0);
    check(mem_line[0][95:64] == 32'hDEAD_0002, "R7 written word reached memory",
          mem_line[0][95:64], 32'hDEAD_0002);
    check(mem_line[0][31:0] == init_word(0), "R7 other words preserved",
          mem_line[0][31:0], init_word(0));
    access(32'd8, 1'b0, '0, 1'b0, 32'hDEAD_0002, "R5 refetch after displacement");
    check(wr_cnt == 1, "R8 clean line evicted silently", 32'(wr_cnt), 32'd1);
  endtask

  task automatic t_write_miss;
    access(32'd160, 1'b1, 32'hCAFE_0040, 1'b0, 32'hCAFE_0040, "R11 write miss");
    access(32'd164, 1'b0, '0, 1'b1, init_word(41), "R11 neighbour word from memory");
    access(32'd160, 1'b0, '0, 1'b1, 32'hCAFE_0040, "R11 merged word kept");
  endtask

  task automatic t_split;
    // Index 2, top tag bit set: conflicts with the modified line from word 40.
    access(32'h8000_0024, 1'b0, '0, 1'b0, init_word(9), "R2 upper tag bit separates lines");
    check(last_wb_addr == 32'h0000_00A0, "R2 evicted line address rebuilt from tag and index",
          last_wb_addr, 32'h0000_00A0);
    check(mem_line[10][31:0] == 32'hCAFE_0040, "R7 write-miss data written back",
          mem_line[10][31:0], 32'hCAFE_0040);
    access(32'h8000_0028, 1'b0, '0, 1'b1, init_word(10), "R3 hit on upper-tag line");
  endtask

  task automatic t_backpressure;
    logic [31:0] held;
    bit          ok = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_we = 1'b0; req_addr = 32'h8000_0028;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    held = rsp_data;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (!rsp_valid || rsp_data != held || !rsp_hit || req_ready) ok = 1'b0;
    end
    check(ok, "R10 response held under back-pressure", rsp_data, held);
    check(held == init_word(10), "R10 held data value", held, init_word(10));
    rsp_ready = 1'b1;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R10 response released", 32'(rsp_valid), 32'd0);
  endtask

  initial begin
    for (int l = 0; l < 64; l++)
      for (int k = 0; k < 4; k++)
        mem_line[l][k*32 +: 32] = init_word(l * 4 + k);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_trace();
    t_writeback();
    t_write_miss();
    t_split();
    t_backpressure();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule